// File: doc/BRIEF.md
# Parallel Bus Slave with Refreshed Local RAM

This block sits on an 8-bit parallel system bus and answers as a slave. A master places a 20-bit address and pulls one of four active-low command lines: memory read, memory write, I/O read or I/O write. The block passes the command lines and an active-low inhibit line through a two-flop synchronizer. It then decodes the command against a RAM window and a single I/O port address. When the access has finished, it pulls an active-low transfer acknowledge low. For reads the acknowledge comes only once the data is valid on the bus, and for writes only once the data has been stored.

Local RAM is a register array that needs periodic refresh. A refresh timer raises a request at a fixed cycle period. The controller grants it from idle, and the refresh then occupies the RAM for a fixed number of cycles. A command that meets a pending or running refresh is held back until the refresh ends, which stretches the time to acknowledge.

An asserted inhibit line blocks the memory cycle. In that case nothing is stored and no acknowledge is given, so another device can answer in the same address range. After each acknowledge the slave waits a minimum gap before it accepts the next command.

Top module: `bsl_slave`

## Requirements
- R1: After reset `xack_n` is 1, `dat_oe` is 0, and the I/O register reads back 0x00.
- R2: A memory write at an address A with RAM_BASE <= A < RAM_BASE+RAM_WORDS stores `dat_i` at offset A-RAM_BASE. A later memory read of A returns that byte on `dat_o`, with `dat_oe` = 1 while `xack_n` = 0. Both window edges are included.
- R3: An I/O write to address IO_PORT loads the I/O register. An I/O read of IO_PORT returns the register's value with `dat_oe` = 1 during the acknowledge.
- R4: From idle with no refresh pending, `xack_n` falls exactly ACC_LAT+3 clock edges after the command line falls: two synchronizer edges, one decode edge and ACC_LAT access edges.
- R5: After the command line rises, `xack_n` returns to 1 and `dat_oe` to 0 exactly 3 edges later.
- R6: A memory command outside the window, or an I/O command at any address other than IO_PORT, gets no acknowledge and `dat_oe` stays 0. Memory contents are left unchanged.
- R7: `inh_n` = 0 held with a memory command suppresses that command: there is no acknowledge and no write, and earlier contents survive. I/O commands are not affected by `inh_n`.
- R8: A refresh request is raised every REF_PERIOD cycles and occupies the RAM for REF_LAT cycles. No RAM write happens during a refresh. An acknowledged access takes between ACC_LAT+3 and ACC_LAT+REF_LAT+5 edges.
- R9: After an acknowledge ends, no new command is decoded for SEP_CYC cycles. A command driven at the first sample where `xack_n` is back at 1 is acknowledged SEP_CYC+ACC_LAT+1 edges after it falls.
- R10: All 20 address bits are compared, so an address that matches a window location except in bits 19:16 is outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adr_i | input | ADDR_W | Bus address |
| dat_i | input | DATA_W | Write data from the bus |
| dat_o | output | DATA_W | Read data to the bus |
| dat_oe | output | 1 | Read data drive enable |
| mrdc_n | input | 1 | Memory read command, active low |
| mwtc_n | input | 1 | Memory write command, active low |
| iorc_n | input | 1 | I/O read command, active low |
| iowc_n | input | 1 | I/O write command, active low |
| inh_n | input | 1 | Inhibit of the RAM cycle, active low |
| xack_n | output | 1 | Transfer acknowledge, active low |

## Verification
Two things can fall on the same idle cycle: the refresh timer's request and the decode of a newly synchronized command. The controller gives the refresh priority in that case. The bench provokes these collisions by issuing a long seeded stream of closely spaced accesses against a short refresh period, so commands land at every phase of the refresh timer. The result is judged at the ports in three ways. Every acknowledged latency must lie between the refresh-free value and that value plus REF_LAT+2. Both undelayed and delayed accesses must actually occur. Read data must always match the bench's own memory model, which shows that no write was lost or moved by a refresh.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREF,
        ST_ACCESS,
        ST_ACK,
        ST_HOLD,
        ST_SEP
    } bsl_state_e;

    // bit positions inside the synchronized control vector
    localparam int unsigned CMD_MRD = 0;
    localparam int unsigned CMD_MWT = 1;
    localparam int unsigned CMD_IOR = 2;
    localparam int unsigned CMD_IOW = 3;
    localparam int unsigned CMD_INH = 4;
    localparam int unsigned CMD_N   = 5;

endpackage

// File: rtl/bsl_sync.sv
module bsl_sync #(
    parameter int unsigned W       = 5,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.s1 <= RST_VAL;
            sy_q.s2 <= RST_VAL;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign q_o = sy_q.s2;

endmodule

// File: rtl/bsl_refresh.sv
module bsl_refresh #(
    parameter int unsigned PERIOD = 64,
    parameter int unsigned LAT    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pending_o,
    output logic busy_o
);
    localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int unsigned LW = $clog2(LAT + 1);

    typedef struct packed {
        logic [PW-1:0] per;
        logic          pend;
        logic          busy;
        logic [LW-1:0] cnt;
    } ref_t;

    ref_t rf_d, rf_q;
    logic wrap;

    always_comb begin
        rf_d = rf_q;
        wrap = (rf_q.per == PW'(PERIOD - 1));
        rf_d.per  = wrap ? '0 : rf_q.per + 1'b1;
        rf_d.pend = (rf_q.pend & ~start_i) | wrap;
        if (start_i) begin
            rf_d.busy = 1'b1;
            rf_d.cnt  = LW'(LAT - 1);
        end else if (rf_q.busy) begin
            if (rf_q.cnt == '0) rf_d.busy = 1'b0;
            else                rf_d.cnt  = rf_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign pending_o = rf_q.pend;
    assign busy_o    = rf_q.busy;

    AST_REF_START_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> rf_q.pend); // R8
    AST_REF_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R8

endmodule

// File: rtl/bsl_ram.sv
module bsl_ram #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/bsl_slave.sv
module bsl_slave
    import bsl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned RAM_BASE  = 32'h0000_1000,
    parameter int unsigned RAM_WORDS = 256,
    parameter int unsigned IO_PORT   = 32'h0000_0040,
    parameter int unsigned ACC_LAT   = 3,
    parameter int unsigned REF_LAT   = 4,
    parameter int unsigned REF_PERIOD = 64,
    parameter int unsigned SEP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] adr_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] dat_o,
    output logic              dat_oe,
    input  logic              mrdc_n,
    input  logic              mwtc_n,
    input  logic              iorc_n,
    input  logic              iowc_n,
    input  logic              inh_n,
    output logic              xack_n
);
    localparam int unsigned RAM_AW = $clog2(RAM_WORDS);
    localparam int unsigned CMAX   = (ACC_LAT > SEP_CYC) ? ACC_LAT : SEP_CYC;
    localparam int unsigned CW     = $clog2(CMAX + 1);
    localparam int unsigned GW     = $clog2(SEP_CYC + 1);

    typedef struct packed {
        bsl_state_e        st;
        logic [CW-1:0]     cnt;
        logic              rd;
        logic              io;
        logic [RAM_AW-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic [DATA_W-1:0] ioreg;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [CMD_N-1:0]  raw_n, syn_n;
    logic              mrd, mwt, ior, iow, inh_act, any_cmd, mem_cmd;
    logic              in_win, io_hit, hit;
    logic              ref_pending, ref_busy, ref_start;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    assign raw_n = {inh_n, iowc_n, iorc_n, mwtc_n, mrdc_n};

    bsl_sync #(.W(CMD_N), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw_n), .q_o(syn_n)
    );

    bsl_refresh #(.PERIOD(REF_PERIOD), .LAT(REF_LAT)) u_refresh (
        .clk(clk), .rst_n(rst_n), .start_i(ref_start),
        .pending_o(ref_pending), .busy_o(ref_busy)
    );

    bsl_ram #(.DEPTH(RAM_WORDS), .DW(DATA_W)) u_ram (
        .clk(clk), .we_i(ram_we), .waddr_i(c_q.addr), .wdata_i(c_q.wdat),
        .raddr_i(c_q.addr), .rdata_o(ram_rdata)
    );

    assign mrd     = ~syn_n[CMD_MRD];
    assign mwt     = ~syn_n[CMD_MWT];
    assign ior     = ~syn_n[CMD_IOR];
    assign iow     = ~syn_n[CMD_IOW];
    assign inh_act = ~syn_n[CMD_INH];
    assign mem_cmd = mrd | mwt;
    assign any_cmd = mrd | mwt | ior | iow;

    assign in_win = (32'(adr_i) >= RAM_BASE) && (32'(adr_i) < RAM_BASE + RAM_WORDS);
    assign io_hit = (32'(adr_i) == IO_PORT);
    assign hit    = mem_cmd ? (in_win & ~inh_act) : io_hit;

    always_comb begin
        c_d       = c_q;
        ram_we    = 1'b0;
        ref_start = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (ref_pending) begin
                    ref_start = 1'b1;
                    c_d.st    = ST_WREF;
                end else if (any_cmd) begin
                    c_d.rd   = mrd | (~mwt & ior);
                    c_d.io   = ~mem_cmd;
                    c_d.addr = RAM_AW'(32'(adr_i) - RAM_BASE);
                    c_d.wdat = dat_i;
                    if (hit) begin
                        c_d.st  = ST_ACCESS;
                        c_d.cnt = CW'(ACC_LAT - 1);
                    end else begin
                        c_d.st  = ST_HOLD;
                    end
                end
            end
            ST_WREF: begin
                if (!ref_busy) c_d.st = ST_IDLE;
            end
            ST_ACCESS: begin
                if (c_q.cnt == '0) begin
                    c_d.st = ST_ACK;
                    if (c_q.io) begin
                        if (c_q.rd) c_d.rdat  = c_q.ioreg;
                        else        c_d.ioreg = c_q.wdat;
                    end else begin
                        if (c_q.rd) c_d.rdat = ram_rdata;
                        else        ram_we   = 1'b1;
                    end
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_ACK, ST_HOLD: begin
                if (!any_cmd) begin
                    c_d.st  = ST_SEP;
                    c_d.cnt = CW'(SEP_CYC - 1);
                end
            end
            ST_SEP: begin
                if (c_q.cnt == '0) c_d.st  = ST_IDLE;
                else               c_d.cnt = c_q.cnt - 1'b1;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign xack_n = ~(c_q.st == ST_ACK);
    assign dat_oe = (c_q.st == ST_ACK) & c_q.rd;
    assign dat_o  = c_q.rdat;

    // cycles with acknowledge high since the last acknowledge, saturating
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    gap_q <= GW'(SEP_CYC);
        else if (!xack_n)              gap_q <= '0;
        else if (gap_q != GW'(SEP_CYC)) gap_q <= gap_q + 1'b1;
    end

    AST_WE_NOT_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !ref_busy); // R8
    AST_ACK_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xack_n) |-> any_cmd); // R2
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!xack_n && !any_cmd) |=> (xack_n && !dat_oe)); // R5
    AST_INH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && !ref_pending && mem_cmd && inh_act) |=> (c_q.st == ST_HOLD)); // R7
    AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE && !ref_pending && mem_cmd && !in_win) |=> (c_q.st == ST_HOLD)); // R6
    AST_SEP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xack_n) |-> (gap_q >= GW'(SEP_CYC))); // R9

endmodule

// File: tb/bsl_slave_tb.sv
module bsl_slave_tb;
    localparam int unsigned ACC    = 3;
    localparam int unsigned RLAT   = 4;
    localparam int unsigned RPER   = 64;
    localparam int unsigned SEP    = 4;
    localparam int unsigned BASE_A = 32'h0000_1000;
    localparam int unsigned WORDS  = 256;
    localparam int unsigned IOP    = 32'h0000_0040;
    localparam int          LAT0   = ACC + 3;
    localparam int          LATMAX = ACC + RLAT + 5;
    localparam int          MAXW   = 24;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [19:0] adr;
    logic [7:0] dat_i, dat_o;
    logic       dat_oe, xack_n;
    logic       mrdc_n, mwtc_n, iorc_n, iowc_n, inh_n;

    always #10 clk = ~clk;

    bsl_slave #(
        .RAM_BASE(BASE_A), .RAM_WORDS(WORDS), .IO_PORT(IOP),
        .ACC_LAT(ACC), .REF_LAT(RLAT), .REF_PERIOD(RPER), .SEP_CYC(SEP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .adr_i(adr), .dat_i(dat_i), .dat_o(dat_o),
        .dat_oe(dat_oe), .mrdc_n(mrdc_n), .mwtc_n(mwtc_n), .iorc_n(iorc_n),
        .iowc_n(iowc_n), .inh_n(inh_n), .xack_n(xack_n)
    );

    int nchk = 0, nfail = 0;
    int n_fast = 0, n_slow = 0;
    bit done = 0;
    logic [7:0] mem_m [WORDS];
    bit         val_m [WORDS];
    logic [7:0] io_m;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    // kind: 0 mem read, 1 mem write, 2 io read, 3 io write
    task automatic do_op(input int kind, input logic [19:0] a, input logic [7:0] d,
                         input bit inh, input bit quick,
                         output bit acked, output int lat, output logic [7:0] rd);
        bit oe_bad;
        int off;
        adr = a; dat_i = d; inh_n = ~inh;
        case (kind)
            0: mrdc_n = 1'b0;
            1: mwtc_n = 1'b0;
            2: iorc_n = 1'b0;
            default: iowc_n = 1'b0;
        endcase
        acked = 0; lat = 0; rd = '0; oe_bad = 0;
        for (int i = 1; i <= MAXW; i++) begin
            @(posedge clk); @(negedge clk);
            if (!xack_n) begin
                acked = 1; lat = i; rd = dat_o;
                if ((kind == 0 || kind == 2) && !dat_oe) oe_bad = 1;
                if ((kind == 1 || kind == 3) && dat_oe)  oe_bad = 1;
                break;
            end else if (dat_oe) begin
                oe_bad = 1;
            end
        end
        chk(!oe_bad, "R2/R6 data drive only on read acknowledge", int'(oe_bad), 0);
        mrdc_n = 1'b1; mwtc_n = 1'b1; iorc_n = 1'b1; iowc_n = 1'b1; inh_n = 1'b1;
        if (acked) begin
            off = 0;
            for (int i = 1; i <= 6; i++) begin
                @(posedge clk); @(negedge clk);
                if (xack_n && !dat_oe) begin off = i; break; end
            end
            chk(off == 3, "R5 acknowledge turn-off edges", off, 3);
        end
        if (!quick) repeat (8) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        bit ack; int lat; logic [7:0] rd;
        void'($urandom(32'd7319));
        for (int i = 0; i < int'(WORDS); i++) val_m[i] = 0;
        rst_n = 0; adr = '0; dat_i = '0;
        mrdc_n = 1; mwtc_n = 1; iorc_n = 1; iowc_n = 1; inh_n = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk(xack_n == 1'b1, "R1 reset acknowledge idle", int'(xack_n), 1);
        chk(dat_oe == 1'b0, "R1 reset no data drive", int'(dat_oe), 0);

        // R1 R3 R4: first I/O read straight after reset, back-to-back follow-up
        do_op(2, 20'(IOP), 8'h00, 0, 1, ack, lat, rd);
        chk(ack, "R3 io read acknowledged", int'(ack), 1);
        chk(lat == LAT0, "R4 idle latency", lat, LAT0);
        chk(rd == 8'h00, "R1 io register reset value", int'(rd), 0);
        // R9: command driven at once after acknowledge release
        do_op(3, 20'(IOP), 8'h5A, 0, 0, ack, lat, rd);
        chk(lat == int'(SEP + ACC + 1), "R9 separation latency", lat, int'(SEP + ACC + 1));
        io_m = 8'h5A;
        do_op(2, 20'(IOP), 8'h00, 0, 0, ack, lat, rd);
        chk(ack && rd == 8'h5A, "R3 io read back", int'(rd), 8'h5A);

        // R2: window edges
        do_op(1, 20'(BASE_A), 8'h11, 0, 0, ack, lat, rd);
        chk(ack, "R2 write at window start", int'(ack), 1);
        do_op(1, 20'(BASE_A + WORDS - 1), 8'hEE, 0, 0, ack, lat, rd);
        chk(ack, "R2 write at window end", int'(ack), 1);
        mem_m[0] = 8'h11; val_m[0] = 1; mem_m[WORDS-1] = 8'hEE; val_m[WORDS-1] = 1;
        do_op(0, 20'(BASE_A), 8'h00, 0, 0, ack, lat, rd);
        chk(ack && rd == 8'h11, "R2 read window start", int'(rd), 8'h11);
        do_op(0, 20'(BASE_A + WORDS - 1), 8'h00, 0, 0, ack, lat, rd);
        chk(ack && rd == 8'hEE, "R2 read window end", int'(rd), 8'hEE);

        // R6: just outside the window, wrong port
        do_op(1, 20'(BASE_A + WORDS), 8'h77, 0, 0, ack, lat, rd);
        chk(!ack, "R6 write above window ignored", int'(ack), 0);
        do_op(0, 20'(BASE_A - 1), 8'h00, 0, 0, ack, lat, rd);
        chk(!ack, "R6 read below window ignored", int'(ack), 0);
        do_op(2, 20'(IOP + 1), 8'h00, 0, 0, ack, lat, rd);
        chk(!ack, "R6 io read of other port ignored", int'(ack), 0);

        // R7: inhibit blocks memory, not I/O
        do_op(1, 20'(BASE_A), 8'h99, 1, 0, ack, lat, rd);
        chk(!ack, "R7 inhibited write not acknowledged", int'(ack), 0);
        do_op(0, 20'(BASE_A), 8'h00, 0, 0, ack, lat, rd);
        chk(ack && rd == 8'h11, "R7 inhibited write left memory", int'(rd), 8'h11);
        do_op(3, 20'(IOP), 8'hC3, 1, 0, ack, lat, rd);
        chk(ack, "R7 io write ignores inhibit", int'(ack), 1);
        io_m = 8'hC3;

        // R10: upper address bits take part in the compare
        do_op(1, 20'(BASE_A + 32'h1_0000), 8'h55, 0, 0, ack, lat, rd);
        chk(!ack, "R10 alias in bits 19:16 ignored", int'(ack), 0);
        do_op(0, 20'(BASE_A), 8'h00, 0, 0, ack, lat, rd);
        chk(ack && rd == 8'h11, "R10 alias did not write", int'(rd), 8'h11);

        // seeded random mix against the refresh timer
        for (int n = 0; n < 250; n++) begin
            int r, o;
            logic [7:0] d;
            r = int'($urandom_range(0, 6));
            o = int'($urandom_range(0, WORDS - 1));
            d = 8'($urandom);
            if (r == 1 && !val_m[o]) r = 0;
            case (r)
                0: begin
                    do_op(1, 20'(BASE_A + o), d, 0, 0, ack, lat, rd);
                    chk(ack, "R2 random write acknowledged", int'(ack), 1);
                    mem_m[o] = d; val_m[o] = 1;
                end
                1: begin
                    do_op(0, 20'(BASE_A + o), 8'h00, 0, 0, ack, lat, rd);
                    chk(ack && rd == mem_m[o], "R2 random read data", int'(rd), int'(mem_m[o]));
                end
                2: begin
                    do_op(3, 20'(IOP), d, 0, 0, ack, lat, rd);
                    chk(ack, "R3 random io write", int'(ack), 1);
                    io_m = d;
                end
                3: begin
                    do_op(2, 20'(IOP), 8'h00, 0, 0, ack, lat, rd);
                    chk(ack && rd == io_m, "R3 random io read", int'(rd), int'(io_m));
                end
                4: begin
                    do_op(int'($urandom_range(0, 1)), 20'(BASE_A + WORDS + o), d, 0, 0, ack, lat, rd);
                    chk(!ack, "R6 random out of window", int'(ack), 0);
                end
                5: begin
                    do_op(1, 20'(BASE_A + o), d, 1, 0, ack, lat, rd);
                    chk(!ack, "R7 random inhibited write", int'(ack), 0);
                end
                default: begin
                    do_op(1, 20'(BASE_A + o + 32'h4_0000), d, 0, 0, ack, lat, rd);
                    chk(!ack, "R10 random high alias", int'(ack), 0);
                end
            endcase
            if (ack) begin
                chk(lat >= LAT0 && lat <= LATMAX, "R8 latency within refresh bound", lat, LATMAX);
                if (lat == LAT0) n_fast++;
                else             n_slow++;
            end
        end
        chk(n_slow > 0, "R8 some accesses delayed by refresh", n_slow, 1);
        chk(n_fast > 0, "R4 some accesses free of refresh", n_fast, 1);
        summary();
    end

endmodule